// File: doc/BRIEF.md
# FFT Block Validity Gate

This block sits around a channeliser's FFT and decides, for every transform block and every input stream, whether the block may take part in correlation. Each incoming sample carries the good/bad flag of the data frame it came from. The flag is captured once per frame, at the frame's first sample, and it applies until the next frame starts. Frames and transform blocks need not line up, so one block can draw on two frames. Because a six-tap pre-filter feeds each transform, a block's verdict combines its own samples with those of the five blocks before it. Any bad frame anywhere in that six-block window makes the block bad.

Verdicts wait in a short in-order queue until the transform output of the same block passes through. An output block that is judged bad is replaced by zeros lane by lane, and a per-lane flag marks it. The first six blocks after an integration starts are always bad, because the pre-filter is still refilling. One saturating counter for each unordered stream pair, autocorrelations included, counts the blocks in which both streams were good. The host reads these counts to normalise the products.

Integration control is a four-state machine. IDLE is the state after reset. START takes any state to FILL when `int_start` pulses, and `int_start` wins over `int_end`. FILLED moves FILL to RUN when the sixth block of the integration completes. END moves FILL or RUN to HOLD when `int_end` pulses, and HOLD keeps the counts for readout.

Top module: `fft_valid_gate`

## Requirements
- R1: After reset `out_vld`, `out_sob` and `out_ok` are 0, and every counter reads 0.
- R2: A stream's frame flag is taken from `in_frame_ok` on a sample with `in_sof`=1. It covers that sample and each later sample up to the next `in_sof`. Before the first `in_sof` the flag is bad.
- R3: Blocks are runs of FFT_LEN consecutive `in_vld` samples, counted from reset or `int_start`. In RUN a stream's block is good only if every sample of that block and of the 5 blocks before it carried a good frame flag.
- R4: Blocks that complete in IDLE, FILL or HOLD are bad. FILL covers the first 6 blocks after `int_start`, so these are always bad.
- R5: Each `fft_vld` beat produces one `out_vld` beat on the next cycle. `out_sob` is 1 on the first beat of each FFT_LEN-beat output block. Lane s of `out_data` (bits s*DW up to s*DW+DW-1) equals the input lane when `out_ok[s]`=1 and is zero otherwise. `out_ok` is the block's verdict, held for all its beats.
- R6: Verdicts reach output blocks in completion order. An output block that finds no pending verdict is bad in every lane. `int_start` discards pending verdicts.
- R7: The counter for pair (a,b) with a<=b sits at index a*NS - a*(a-1)/2 + (b-a). During FILL or RUN it rises by 1 on each output block whose verdict is good in both lane a and lane b.
- R8: `int_start` clears every counter, and the readout shows 0 from the next cycle.
- R9: After `int_end` the counters hold their values, and later blocks are bad until the next `int_start`.
- R10: A counter at its all-ones value stays there and never wraps.
- R11: `rd_cnt` shows the counter selected by `rd_idx` in the same cycle. An index of NS*(NS+1)/2 or more reads 0.
- R12: The block moves from FILL to RUN exactly when the sixth block after `int_start` completes, so block index 5 is bad and block index 6 can be good.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| int_start | input | 1 | Integration start pulse |
| int_end | input | 1 | Integration end pulse |
| in_vld | input | 1 | Input sample beat |
| in_sof | input | 1 | First sample of a new frame |
| in_frame_ok | input | NS | Per-stream frame flag, read with in_sof |
| fft_vld | input | 1 | Transform output beat |
| fft_data | input | NS*DW | Transform output, one DW lane per stream |
| out_vld | output | 1 | Gated output beat |
| out_sob | output | 1 | First beat of an output block |
| out_ok | output | NS | Per-stream block verdict |
| out_data | output | NS*DW | Gated data, zero in bad lanes |
| rd_idx | input | PIDX_W | Counter select |
| rd_cnt | output | CNT_W | Selected counter value |

## Verification
The bench places bad frames so that they straddle block edges. A design that sampled frame flags per block instead of per sample, or that kept fewer than five blocks of history, would pass blocks that should fail. It checks blocks 5 and 6 of an integration, where an off-by-one fill count would wrongly pass block 5 or wrongly fail block 6. It leaves a good verdict pending across `int_start`, which catches a queue that is not flushed and would let a stale good verdict leak into the new integration. It also drives a counter past its ceiling and reads beyond the last index, exposing wrap-around and decode aliasing.

// File: rtl/fvg_pkg.sv
package fvg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FILL,
        ST_RUN,
        ST_HOLD
    } phase_e;

    // position of unordered pair (a,b), a<=b, in the counter bank
    function automatic int pair_pos(input int a, input int b, input int n);
        return a * n - (a * (a - 1)) / 2 + (b - a);
    endfunction

endpackage

// File: rtl/fvg_window.sv
module fvg_window #(
    parameter int TAPS = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic smp_vld,
    input  logic smp_sof,
    input  logic frm_ok,
    input  logic blk_last,
    output logic blk_ok
);
    localparam int HW = TAPS - 1;

    logic          frm_q;
    logic          run_q;
    logic [HW-1:0] hist_q;
    logic          eff;
    logic          blk_bit;

    assign eff     = smp_sof ? frm_ok : frm_q;
    assign blk_bit = run_q & eff;
    assign blk_ok  = blk_bit & (&hist_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frm_q  <= 1'b0;
            run_q  <= 1'b1;
            hist_q <= '0;
        end else begin
            if (smp_vld && smp_sof)
                frm_q <= frm_ok;
            if (restart) begin
                run_q  <= 1'b1;
                hist_q <= '0;
            end else if (smp_vld) begin
                if (blk_last) begin
                    run_q  <= 1'b1;
                    hist_q <= (hist_q << 1) | HW'(blk_bit);
                end else begin
                    run_q <= blk_bit;
                end
            end
        end
    end

    // R3
    bad_block_poison_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && blk_last && !blk_bit && !restart) |=> !blk_ok);

endmodule

// File: rtl/fvg_vq.sv
module fvg_vq #(
    parameter int W     = 4,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [AW:0]   cnt;

    assign empty = (cnt == '0);
    assign dout  = mem[rp];

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) begin
                mem[wp] <= din;
                wp      <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            end
            if (pop)
                rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            cnt <= cnt + (AW+1)'(push) - (AW+1)'(pop);
        end
    end

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !flush) |-> (cnt != (AW+1)'(DEPTH)));

    // R6
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

endmodule

// File: rtl/fvg_pcnt.sv
module fvg_pcnt #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            cnt <= '0;
        else if (en && inc && (cnt != '1))
            cnt <= cnt + 1'b1;
    end

    // R8
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));

    // R10
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && cnt == '1) |=> (cnt == '1));

    // R9
    frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !en) |=> $stable(cnt));

    // R7
    unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((cnt == $past(cnt)) || (cnt == W'($past(cnt) + 1'b1))));

endmodule

// File: rtl/fft_valid_gate.sv
module fft_valid_gate
    import fvg_pkg::*;
#(
    parameter int NS       = 4,
    parameter int DW       = 16,
    parameter int FFT_LEN  = 8,
    parameter int TAPS     = 6,
    parameter int FILL     = 6,
    parameter int VQ_DEPTH = 4,
    parameter int CNT_W    = 32,
    localparam int NP      = NS * (NS + 1) / 2,
    localparam int PIDX_W  = $clog2(NP)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               int_start,
    input  logic               int_end,
    input  logic               in_vld,
    input  logic               in_sof,
    input  logic [NS-1:0]      in_frame_ok,
    input  logic               fft_vld,
    input  logic [NS*DW-1:0]   fft_data,
    output logic               out_vld,
    output logic               out_sob,
    output logic [NS-1:0]      out_ok,
    output logic [NS*DW-1:0]   out_data,
    input  logic [PIDX_W-1:0]  rd_idx,
    output logic [CNT_W-1:0]   rd_cnt
);
    localparam int BIN_W  = $clog2(FFT_LEN);
    localparam int FILL_W = $clog2(FILL + 1);

    phase_e state, nxt;
    logic [BIN_W-1:0]  in_cnt, out_cnt;
    logic [FILL_W-1:0] fill_cnt;
    logic blk_last, blk_done, push, pop, vq_empty, first, cnt_en, pass_en;
    logic [NS-1:0] win_ok, push_data, vq_dout, ok_now, cur_ok;
    logic [CNT_W-1:0] cnt_arr [NP];

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        if (int_start) begin
            nxt = ST_FILL;
        end else begin
            unique case (state)
                ST_IDLE: nxt = ST_IDLE;
                ST_FILL: begin
                    if (int_end)
                        nxt = ST_HOLD;
                    else if (blk_done && fill_cnt == FILL_W'(FILL - 1))
                        nxt = ST_RUN;
                end
                ST_RUN:  if (int_end) nxt = ST_HOLD;
                ST_HOLD: nxt = ST_HOLD;
            endcase
        end
    end

    // ---------------- state-derived outputs ----------------
    always_comb begin
        cnt_en  = 1'b0;
        pass_en = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_FILL: cnt_en = 1'b1;
            ST_RUN: begin
                cnt_en  = 1'b1;
                pass_en = 1'b1;
            end
            ST_HOLD: ;
        endcase
    end

    // ---------------- input block framing ----------------
    assign blk_last = (in_cnt == BIN_W'(FFT_LEN - 1));
    assign blk_done = in_vld && blk_last;

    always_ff @(posedge clk) begin
        if (!rst_n || int_start) begin
            in_cnt   <= '0;
            fill_cnt <= '0;
        end else begin
            if (in_vld)
                in_cnt <= blk_last ? '0 : in_cnt + 1'b1;
            if (blk_done && state == ST_FILL)
                fill_cnt <= fill_cnt + 1'b1;
        end
    end

    for (genvar s = 0; s < NS; s++) begin : g_win
        fvg_window #(.TAPS(TAPS)) u_win (
            .clk      (clk),
            .rst_n    (rst_n),
            .restart  (int_start),
            .smp_vld  (in_vld),
            .smp_sof  (in_sof),
            .frm_ok   (in_frame_ok[s]),
            .blk_last (blk_last),
            .blk_ok   (win_ok[s])
        );
    end

    assign push      = blk_done && !int_start;
    assign push_data = win_ok & {NS{pass_en}};

    fvg_vq #(.W(NS), .DEPTH(VQ_DEPTH)) u_vq (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (int_start),
        .push  (push),
        .din   (push_data),
        .pop   (pop),
        .dout  (vq_dout),
        .empty (vq_empty)
    );

    // ---------------- output side ----------------
    assign first  = (out_cnt == '0);
    assign pop    = fft_vld && first && !vq_empty && !int_start;
    assign ok_now = first ? (vq_empty ? '0 : vq_dout) : cur_ok;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_cnt  <= '0;
            cur_ok   <= '0;
            out_vld  <= 1'b0;
            out_sob  <= 1'b0;
            out_ok   <= '0;
            out_data <= '0;
        end else begin
            if (fft_vld) begin
                out_cnt <= (out_cnt == BIN_W'(FFT_LEN - 1)) ? '0 : out_cnt + 1'b1;
                if (first) cur_ok <= ok_now;
            end
            out_vld <= fft_vld;
            out_sob <= fft_vld && first;
            out_ok  <= fft_vld ? ok_now : '0;
            for (int s = 0; s < NS; s++)
                out_data[s*DW +: DW] <= (fft_vld && ok_now[s]) ? fft_data[s*DW +: DW] : '0;
        end
    end

    // ---------------- per-pair counters ----------------
    for (genvar a = 0; a < NS; a++) begin : g_a
        for (genvar b = a; b < NS; b++) begin : g_b
            localparam int P = pair_pos(a, b, NS);
            fvg_pcnt #(.W(CNT_W)) u_cnt (
                .clk   (clk),
                .rst_n (rst_n),
                .clr   (int_start),
                .en    (cnt_en),
                .inc   (fft_vld && first && ok_now[a] && ok_now[b]),
                .cnt   (cnt_arr[P])
            );
        end
    end

    always_comb begin
        rd_cnt = '0;
        for (int p = 0; p < NP; p++)
            if (rd_idx == PIDX_W'(p)) rd_cnt = cnt_arr[p];
    end

    // ---------------- assertions ----------------
    for (genvar s = 0; s < NS; s++) begin : g_chk
        // R5
        zero_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (out_vld && !out_ok[s]) |-> (out_data[s*DW +: DW] == '0));
    end

    // R5
    quiet_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_vld |-> (out_ok == '0 && !out_sob));

    // R12
    run_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_RUN) |-> ($past(state) == ST_FILL && $past(fill_cnt) == FILL_W'(FILL - 1)));

    // R9
    hold_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && !int_start) |=> (state == ST_HOLD));

    // R4
    fill_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && state != ST_RUN) |=> !$past(push_data[0]));

endmodule

// File: tb/test_fft_valid_gate.sv
module test_fft_valid_gate;
    localparam int NS = 4, DW = 16, FFT_LEN = 8, FILL = 6, CNT_W = 4, FRM = 12;
    localparam int NP = NS * (NS + 1) / 2;
    localparam int PIDX_W = $clog2(NP);
    localparam int SAT = (1 << CNT_W) - 1;

    logic clk = 1'b0, rst_n = 1'b0;
    logic int_start = 0, int_end = 0, in_vld = 0, in_sof = 0, fft_vld = 0;
    logic [NS-1:0] in_frame_ok = '0;
    logic [NS*DW-1:0] fft_data = '0;
    logic out_vld, out_sob;
    logic [NS-1:0] out_ok;
    logic [NS*DW-1:0] out_data;
    logic [PIDX_W-1:0] rd_idx = '0;
    logic [CNT_W-1:0] rd_cnt;

    int total = 0, bad = 0, cyc = 0;
    int samp = 0;
    int exp_cnt [NP];

    always #2 clk = ~clk;

    fft_valid_gate #(.NS(NS), .DW(DW), .FFT_LEN(FFT_LEN), .FILL(FILL), .CNT_W(CNT_W))
    i_fft_valid_gate (
        .clk(clk), .rst_n(rst_n), .int_start(int_start), .int_end(int_end),
        .in_vld(in_vld), .in_sof(in_sof), .in_frame_ok(in_frame_ok),
        .fft_vld(fft_vld), .fft_data(fft_data), .out_vld(out_vld), .out_sob(out_sob),
        .out_ok(out_ok), .out_data(out_data), .rd_idx(rd_idx), .rd_cnt(rd_cnt)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            total++; bad++;
            $display("FAIL watchdog: run hung, actual=%0d cycles expected<100000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit good, input string tag, input longint act, input longint exp);
        total++;
        if (!good) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit frame_bad(input int s, input int f);
        return (s == 1 && f == 9) || (s == 2 && f == 3);
    endfunction

    function automatic bit exp_ok(input int s, input int kabs, input int kint, input bit running);
        if (!running || kint < FILL) return 0;
        for (int t = FFT_LEN * (kabs - 5); t < FFT_LEN * (kabs + 1); t++)
            if (frame_bad(s, t / FRM)) return 0;
        return 1;
    endfunction

    task automatic pulse_start();
        @(negedge clk); int_start = 1;
        @(negedge clk); int_start = 0;
        for (int p = 0; p < NP; p++) exp_cnt[p] = 0;
    endtask

    task automatic pulse_end();
        @(negedge clk); int_end = 1;
        @(negedge clk); int_end = 0;
    endtask

    task automatic feed_in_block();
        for (int i = 0; i < FFT_LEN; i++) begin
            @(negedge clk);
            in_vld = 1;
            in_sof = (samp % FRM == 0);
            for (int s = 0; s < NS; s++) in_frame_ok[s] = !frame_bad(s, samp / FRM);
            samp++;
        end
        @(negedge clk);
        in_vld = 0; in_sof = 0;
    endtask

    task automatic feed_out_block(input logic [NS-1:0] eok, input int kabs, input string tag);
        for (int i = 0; i < FFT_LEN; i++) begin
            @(negedge clk);
            fft_vld = 1;
            for (int s = 0; s < NS; s++)
                fft_data[s*DW +: DW] = DW'((s << 12) | ((kabs & 255) << 4) | i);
            @(negedge clk);
            fft_vld = 0;
            chk(out_vld == 1'b1, "R5 out_vld", out_vld, 1);
            chk(out_sob == (i == 0), "R5 out_sob", out_sob, (i == 0));
            chk(out_ok == eok, tag, out_ok, eok);
            for (int s = 0; s < NS; s++)
                chk(out_data[s*DW +: DW] == (eok[s] ? fft_data[s*DW +: DW] : '0), "R5 lane data",
                    out_data[s*DW +: DW], eok[s] ? fft_data[s*DW +: DW] : '0);
        end
    endtask

    task automatic blk_pair(input int kint, input bit running);
        logic [NS-1:0] eok;
        int kabs, p;
        kabs = samp / FFT_LEN;
        for (int s = 0; s < NS; s++) eok[s] = exp_ok(s, kabs, kint, running);
        feed_in_block();
        // R12 boundary: kint 5 stays bad, kint 6 may be good
        feed_out_block(eok, kabs, (kint < FILL) ? "R4 R12 fill verdict" : "R2 R3 window verdict");
        p = 0;
        for (int a = 0; a < NS; a++)
            for (int b = a; b < NS; b++) begin
                if (running && eok[a] && eok[b] && exp_cnt[p] < SAT) exp_cnt[p]++;
                p++;
            end
    endtask

    task automatic check_counts(input string tag);
        for (int p = 0; p < NP; p++) begin
            @(negedge clk);
            rd_idx = PIDX_W'(p);
            #1;
            chk(rd_cnt == CNT_W'(exp_cnt[p]), tag, rd_cnt, exp_cnt[p]);
        end
    endtask

    task automatic t_reset();
        // R1
        chk(out_vld == 0 && out_sob == 0, "R1 outputs idle", {out_vld, out_sob}, 0);
        chk(out_ok == '0, "R1 out_ok", out_ok, 0);
        for (int p = 0; p < NP; p++) exp_cnt[p] = 0;
        check_counts("R1 counter reset");
    endtask

    task automatic t_empty_out();
        // R6: no verdict pending, block must be blanked
        feed_out_block('0, 0, "R6 empty queue verdict");
    endtask

    task automatic t_integration();
        pulse_start();
        for (int k = 0; k < 20; k++) blk_pair(k, 1);
        check_counts("R7 pair counts");
        pulse_end();
        for (int k = 0; k < 3; k++) blk_pair(20 + k, 0);
        check_counts("R9 counts held after end");
    endtask

    task automatic t_saturate();
        pulse_start();
        for (int k = 0; k < 22; k++) blk_pair(k, 1);
        check_counts("R10 saturated counts");
    endtask

    task automatic t_range();
        for (int i = NP; i < (1 << PIDX_W); i++) begin
            @(negedge clk);
            rd_idx = PIDX_W'(i);
            #1;
            chk(rd_cnt == '0, "R11 out of range read", rd_cnt, 0);
        end
    endtask

    task automatic t_flush();
        int kabs;
        kabs = samp / FFT_LEN;
        feed_in_block();
        pulse_start();
        feed_out_block('0, kabs, "R6 flushed verdict");
        check_counts("R8 cleared counts");
        blk_pair(0, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_empty_out();
        t_integration();
        t_saturate();
        t_range();
        t_flush();
        repeat (3) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule